// File: doc/BRIEF.md
# Interlaced 525-Line Sync Timing Generator

This block produces the discrete timing strobes that a video encoder running as a timing slave needs for 525-line interlaced NTSC. It counts clock cycles within each line and lines within each frame. From those two counts it derives horizontal sync, vertical sync, the field identifier and an active-picture flag. It also drives a pixel index and a line number that an upstream pixel source uses to fetch the matching sample. It advances only on cycles where the clock enable is high. With the default parameters, a 27 MHz enable rate gives 1716 cycles per line and a frame rate of 29.97 Hz.

The frame holds two fields, each with 240 picture lines. Vertical sync in the first field covers whole lines. In the second field it starts and ends at the middle of a line. Every output comes from a flop, and all of them describe the same line and cycle position.

Top module: `ntsc_sync_gen`

## Requirements
- R1: The cycle position runs from 1 to LINE_CYCLES and then wraps to 1. The line position steps by one at each wrap and runs from 1 to 525, then returns to 1. `line_num` reports the current 1-based line.
- R2: `hsync` is 1 exactly on cycles 1 to HSYNC_LEN of every line.
- R3: `active` is 1 only when both of these hold:
  - the cycle lies in ACT_START to ACT_START+ACT_LEN-1;
  - the line lies in 22–261 or 285–524.
- R4: In the first field, `vsync` is 1 for the whole of lines 4, 5 and 6, from cycle 1 of line 4 through the last cycle of line 6.
- R5: In the second field, `vsync` is 1 from cycle MID of line 266 through cycle MID-1 of line 269, where MID = LINE_CYCLES/2 + 1. It is 1 for the whole of lines 267 and 268.
- R6: `field` is 0 on lines 1–263 and 1 on lines 264–525. It changes only at cycle 1 of a line.
- R7: While `active` is 1, `pix_idx` equals (cycle − ACT_START)/2, rounded down. Otherwise it is 0.
- R8: While reset is asserted and after it is released, the outputs show line 1, cycle 1: `hsync`=1, `vsync`=0, `field`=0, `active`=0, `pix_idx`=0 and `line_num`=1.
- R9: A cycle with `ce` low changes no output and does not advance the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce | input | 1 | Clock enable; the position advances once per high cycle |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| field | output | 1 | Field identifier: 0 for the first field, 1 for the second |
| active | output | 1 | High during active picture |
| pix_idx | output | $clog2(ACT_LEN/2) | Pixel index within the active line |
| line_num | output | 10 | Current line number, 1-based |

## Verification
If the cycle counter were wrong, `hsync` edges would land off cycles 1 and HSYNC_LEN+1 within the same line. If the line counter were wrong, `field`, `vsync` or `active` would switch on the wrong line, and `line_num` would disagree at the very next compare. A mid-line decode error shows only in the second-field vertical interval, so the bench runs a whole frame and compares every output on every enabled cycle. Gaps in `ce` expose any position that advances while it should hold.

// File: rtl/ntsc_sync_pkg.sv
package ntsc_sync_pkg;
  localparam int unsigned FRAME_LINES  = 525;
  localparam int unsigned LINE_W       = 10;
  localparam int unsigned VS1_FIRST    = 4;
  localparam int unsigned VS1_LAST     = 6;
  localparam int unsigned VS2_FIRST    = 266;
  localparam int unsigned VS2_LAST     = 269;
  localparam int unsigned PIC1_FIRST   = 22;
  localparam int unsigned PIC1_LAST    = 261;
  localparam int unsigned PIC2_FIRST   = 285;
  localparam int unsigned PIC2_LAST    = 524;
  localparam int unsigned FIELD2_FIRST = 264;

  typedef struct packed {
    logic hsync;
    logic vsync;
    logic field;
    logic active;
  } sync_flags_t;
endpackage

// File: rtl/ntsc_hcount.sv
module ntsc_hcount #(
  parameter int unsigned LINE_CYCLES = 1716,
  localparam int unsigned CW = $clog2(LINE_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  output logic [CW-1:0] cyc_q,
  output logic [CW-1:0] cyc_d,
  output logic          eol
);
  always_comb begin
    eol   = (cyc_q == CW'(LINE_CYCLES));
    cyc_d = cyc_q;
    if (ce) cyc_d = eol ? CW'(1) : cyc_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= CW'(1);
    else        cyc_q <= cyc_d;
  end

  // R1
  cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && cyc_q == CW'(LINE_CYCLES)) |=> (cyc_q == CW'(1)));
  // R9
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(cyc_q));
endmodule

// File: rtl/ntsc_vcount.sv
module ntsc_vcount
  import ntsc_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              eol,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_d
);
  logic last_line;

  always_comb begin
    last_line = (line_q == LINE_W'(FRAME_LINES));
    line_d    = line_q;
    if (ce && eol) line_d = last_line ? LINE_W'(1) : line_q + LINE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= LINE_W'(1);
    else        line_q <= line_d;
  end

  // R1
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && eol && line_q == LINE_W'(FRAME_LINES)) |=> (line_q == LINE_W'(1)));
  // R1
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce && eol) |=> $stable(line_q));
endmodule

// File: rtl/ntsc_sync_decode.sv
module ntsc_sync_decode
  import ntsc_sync_pkg::*;
#(
  parameter int unsigned LINE_CYCLES = 1716,
  parameter int unsigned HSYNC_LEN   = 128,
  parameter int unsigned ACT_START   = 245,
  parameter int unsigned ACT_LEN     = 1440,
  localparam int unsigned CW  = $clog2(LINE_CYCLES + 1),
  localparam int unsigned PW  = $clog2(ACT_LEN / 2),
  localparam int unsigned MID = LINE_CYCLES / 2 + 1
) (
  input  logic [CW-1:0]     cyc,
  input  logic [LINE_W-1:0] line,
  output sync_flags_t       flags,
  output logic [PW-1:0]     pix
);
  logic          h_win, v_win, vs_first, vs_second;
  logic [CW-1:0] off;

  always_comb begin
    h_win = (cyc >= CW'(ACT_START)) && (cyc <= CW'(ACT_START + ACT_LEN - 1));
    v_win = ((line >= LINE_W'(PIC1_FIRST)) && (line <= LINE_W'(PIC1_LAST))) ||
            ((line >= LINE_W'(PIC2_FIRST)) && (line <= LINE_W'(PIC2_LAST)));
    vs_first  = (line >= LINE_W'(VS1_FIRST)) && (line <= LINE_W'(VS1_LAST));
    vs_second = ((line == LINE_W'(VS2_FIRST)) && (cyc >= CW'(MID))) ||
                ((line >  LINE_W'(VS2_FIRST)) && (line < LINE_W'(VS2_LAST))) ||
                ((line == LINE_W'(VS2_LAST)) && (cyc < CW'(MID)));
    off = cyc - CW'(ACT_START);

    flags.hsync  = (cyc <= CW'(HSYNC_LEN));
    flags.vsync  = vs_first || vs_second;
    flags.field  = (line >= LINE_W'(FIELD2_FIRST));
    flags.active = h_win && v_win;
    pix          = flags.active ? PW'(off >> 1) : '0;
  end
endmodule

// File: rtl/ntsc_sync_gen.sv
module ntsc_sync_gen
  import ntsc_sync_pkg::*;
#(
  parameter int unsigned LINE_CYCLES = 1716,
  parameter int unsigned HSYNC_LEN   = 128,
  parameter int unsigned ACT_START   = 245,
  parameter int unsigned ACT_LEN     = 1440,
  localparam int unsigned PW = $clog2(ACT_LEN / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  output logic          hsync,
  output logic          vsync,
  output logic          field,
  output logic          active,
  output logic [PW-1:0] pix_idx,
  output logic [9:0]    line_num
);
  localparam int unsigned CW  = $clog2(LINE_CYCLES + 1);
  localparam int unsigned MID = LINE_CYCLES / 2 + 1;

  logic [CW-1:0]     cyc_q, cyc_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              eol;
  sync_flags_t       flags_d;
  logic [PW-1:0]     pix_d;

  ntsc_hcount #(.LINE_CYCLES(LINE_CYCLES)) u_hcount (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .cyc_q(cyc_q), .cyc_d(cyc_d), .eol(eol)
  );

  ntsc_vcount u_vcount (
    .clk(clk), .rst_n(rst_n), .ce(ce), .eol(eol),
    .line_q(line_q), .line_d(line_d)
  );

  // decode the upcoming position so flops line up with the counters
  ntsc_sync_decode #(
    .LINE_CYCLES(LINE_CYCLES), .HSYNC_LEN(HSYNC_LEN),
    .ACT_START(ACT_START), .ACT_LEN(ACT_LEN)
  ) u_decode (
    .cyc(cyc_d), .line(line_d), .flags(flags_d), .pix(pix_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync    <= 1'b1;
      vsync    <= 1'b0;
      field    <= 1'b0;
      active   <= 1'b0;
      pix_idx  <= '0;
      line_num <= 10'd1;
    end else if (ce) begin
      hsync    <= flags_d.hsync;
      vsync    <= flags_d.vsync;
      field    <= flags_d.field;
      active   <= flags_d.active;
      pix_idx  <= pix_d;
      line_num <= 10'(line_d);
    end
  end

  // R2
  hsync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |-> (cyc_q == CW'(1)));
  // R2
  hsync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |-> (cyc_q == CW'(HSYNC_LEN + 1)));
  // R4
  vsync_whole_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(vsync) || $fell(vsync)) && !field) |-> (cyc_q == CW'(1)));
  // R5
  vsync_mid_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(vsync) || $fell(vsync)) && field) |-> (cyc_q == CW'(MID)));
  // R6
  field_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(field) || $fell(field)) |-> (cyc_q == CW'(1)));
  // R7
  pix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pix_idx < PW'(ACT_LEN / 2)));
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> ($stable(hsync) && $stable(vsync) && $stable(line_num) && $stable(pix_idx)));
endmodule

// File: tb/ntsc_sync_gen_tb.sv
module ntsc_sync_gen_tb;
  localparam int LC  = 200;
  localparam int HS  = 16;
  localparam int AS  = 29;
  localparam int AL  = 160;
  localparam int MID = LC / 2 + 1;
  localparam int PW  = $clog2(AL / 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b0;
  logic hsync, vsync, field, active;
  logic [PW-1:0] pix_idx;
  logic [9:0] line_num;

  always #4 clk = ~clk;

  ntsc_sync_gen #(.LINE_CYCLES(LC), .HSYNC_LEN(HS), .ACT_START(AS), .ACT_LEN(AL)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .hsync(hsync), .vsync(vsync),
    .field(field), .active(active), .pix_idx(pix_idx), .line_num(line_num)
  );

  int rl = 1, rc = 1;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural position model
  always @(posedge clk) begin
    if (!rst_n) begin
      rl = 1; rc = 1;
    end else if (ce) begin
      if (rc == LC) begin
        rc = 1;
        rl = (rl == 525) ? 1 : rl + 1;
      end else rc = rc + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s line %0d cyc %0d: actual %0d expected %0d", tag, rl, rc, act, exp);
    end
  endtask

  task automatic check_model();
    int e_act, e_vs, e_pix;
    e_act = (rc >= AS && rc <= AS + AL - 1) &&
            ((rl >= 22 && rl <= 261) || (rl >= 285 && rl <= 524));
    e_vs  = (rl >= 4 && rl <= 6) || (rl == 266 && rc >= MID) ||
            (rl == 267) || (rl == 268) || (rl == 269 && rc < MID);
    e_pix = e_act ? (rc - AS) / 2 : 0;
    chk("R1 line_num", int'(line_num), rl);
    chk("R2 hsync", int'(hsync), int'(rc <= HS));
    chk("R3 active", int'(active), e_act);
    chk((rl < 264) ? "R4 vsync" : "R5 vsync", int'(vsync), e_vs);
    chk("R6 field", int'(field), int'(rl >= 264));
    chk("R7 pix_idx", int'(pix_idx), e_pix);
  endtask

  task automatic check_reset_state();
    chk("R8 hsync", int'(hsync), 1);
    chk("R8 vsync", int'(vsync), 0);
    chk("R8 field", int'(field), 0);
    chk("R8 active", int'(active), 0);
    chk("R8 pix_idx", int'(pix_idx), 0);
    chk("R8 line_num", int'(line_num), 1);
  endtask

  task automatic run(input int cycles, input int gap);
    logic [3:0] snap_f;
    logic [PW-1:0] snap_p;
    logic [9:0] snap_l;
    bit was_off = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_model();
      if (was_off) begin // R9 outputs frozen across a disabled cycle
        chk("R9 flags", int'({hsync, vsync, field, active}), int'(snap_f));
        chk("R9 pix_idx", int'(pix_idx), int'(snap_p));
        chk("R9 line_num", int'(line_num), int'(snap_l));
      end
      snap_f = {hsync, vsync, field, active};
      snap_p = pix_idx;
      snap_l = line_num;
      ce = ((i % gap) != gap - 1);
      was_off = !ce;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ce = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_reset_state(); // R8 during reset
    end
    rst_n = 1'b1;
    ce = 1'b0;
    @(negedge clk);
    check_reset_state(); // R8 after release
  endtask

  initial begin
    do_reset();
    run(20000, 7);
    do_reset();
    run(118000, 13);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule